// File: doc/BRIEF.md
# Serial Audio Stereo Receiver

This block turns a two-channel serial audio stream into parallel samples. A bit clock, a channel-select line and a data line come in from an external codec; the block samples them with its own system clock, finds the start of each channel slot and collects the bits of each sample. Every finished sample goes into a receive queue as its own entry, left channel before right, with the sample placed in the high end of the word. A bus master takes entries out with a one-cycle read strobe and gets the data with a valid flag on the following cycle.

Software sets a fill trigger. A service flag shows when the queue holds at least that many entries, and this flag, gated by a receive-DMA enable, becomes the DMA request. A sticky overrun flag records any sample that arrived while the queue was full. The two flags sit at fixed bits of a four-bit flag word, and an interrupt line is the OR of the flags whose enable bits are set. A flush input empties the queue before a new recording starts.

Top module: `i2s_rx_core`

## Requirements
- R1: Data is sampled on rising bit-clock edges. The rising edge at which a new channel-select level is first seen starts a slot. The sample's MSB is taken at the next rising edge, and the following bits come at one bit per edge. The rising edge that starts the next slot supplies the last bit of a 32-bit sample.
- R2: Channel-select low marks the left slot and high marks the right slot. Each slot's sample is pushed as a separate entry when the next slot starts. After recording is enabled, the first entry pushed is always a left sample.
- R3: size_sel picks the sample width: 00 is 8 bits, 01 is 16 bits, and 10 or 11 is 32 bits. The sample is left-justified in the 32-bit read word, and the low bits are zero.
- R4: The queue holds 32 entries and is read in first-in first-out order. When rd_en is high on a cycle with the queue not empty, rd_valid is high on the next cycle and rd_data holds the oldest entry. A read of an empty queue leaves rd_valid low. The level output gives the number of stored entries.
- R5: svc_flag is high exactly when the level is at or above trig_lvl. The recommended trigger is 7, one less than a quarter of the depth.
- R6: A sample that arrives while the queue is full is dropped and the stored entries are kept unchanged. The same event sets ovr_flag. The flag stays set until an ovr_clr pulse, and a new overrun in the same cycle as the pulse wins.
- R7: irq_flags carries the overrun flag at bit 3 and the service flag at bit 1, with bits 0 and 2 always zero. irq is high when any irq_flags bit is set together with the matching irq_en bit.
- R8: dma_req is high when dma_en is high and svc_flag is high. It does not depend on rec_en.
- R9: A flush pulse empties the queue by the next cycle, and a sample that arrives in the same cycle is discarded.
- R10: While rec_en is low, no sample enters the queue.
- R11: After reset the level is 0 and ovr_flag, irq, dma_req and rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the codec |
| ws_i | input | 1 | Channel select, low = left |
| sd_i | input | 1 | Serial data |
| rec_en | input | 1 | Recording enable |
| dma_en | input | 1 | Receive-DMA request enable |
| size_sel | input | 2 | Sample width select |
| trig_lvl | input | 6 | Service trigger level |
| flush | input | 1 | Queue flush pulse |
| ovr_clr | input | 1 | Overrun clear pulse (write one to clear) |
| irq_en | input | 4 | Interrupt enables, aligned with irq_flags |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, left-justified sample |
| rd_valid | output | 1 | rd_data valid |
| level | output | 6 | Number of stored entries |
| svc_flag | output | 1 | Level at or above trigger |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_flags | output | 4 | Flag word, bit 3 overrun, bit 1 service |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
Every sample in the stream has a distinct value built from a per-sample counter, so a swap of left and right, a bit offset by one edge, or a stale entry all show up as a data mismatch. The stream is sent at 16, 8 and 32 bits. The 32-bit case is the only one whose last bit lands on the slot-start edge, and the 8-bit case shows whether shorter samples are shifted to the top of the word. A 34-sample burst into an empty queue tells apart dropping the newest samples from overwriting the oldest. Level counts of 6 and 8 on either side of trigger 7 show the exact trip point of the service flag. A burst with recording off, and a flush followed by a fresh burst, show that nothing leaks across either action.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_32B = 2'b11
  } smp_size_e;

  // bit positions in the interrupt flag/enable word
  localparam int unsigned FLG_SVC = 1;
  localparam int unsigned FLG_OVR = 3;

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_n;

  always_comb begin
    st_n = {st_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_s,
  input  logic          ws_s,
  input  logic          sd_s,
  input  logic          rec_en,
  input  logic [1:0]    size_sel,
  output logic          push_o,
  output logic [DW-1:0] push_data_o
);

  localparam int unsigned CW = $clog2(DW + 1);

  logic          bclk_q, bclk_n;
  logic          ws_q, ws_n;
  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;

  logic          rise, bnd, take;
  logic [CW-1:0] nbits, shamt;
  logic [DW-1:0] sh_shift;

  always_comb begin
    case (smp_size_e'(size_sel))
      SZ_8:    nbits = CW'(8);
      SZ_16:   nbits = CW'(16);
      default: nbits = CW'(DW);
    endcase
    shamt    = CW'(DW) - nbits;
    rise     = bclk_s & ~bclk_q;
    bnd      = rise & (ws_s ^ ws_q);
    take     = cnt_q < nbits;
    sh_shift = take ? {sh_q[DW-2:0], sd_s} : sh_q;

    bclk_n      = bclk_s;
    ws_n        = ws_q;
    cnt_n       = cnt_q;
    sh_n        = sh_q;
    act_n       = act_q & rec_en;
    push_o      = 1'b0;
    push_data_o = sh_shift << shamt;

    if (rise) begin
      ws_n = ws_s;
      if (bnd) begin
        // slot boundary: bit on this edge closes the previous slot
        push_o = act_q & rec_en;
        cnt_n  = '0;
        sh_n   = '0;
        // recording (re)starts only on a slot that begins the left channel
        act_n  = rec_en & (act_q | ~ws_s);
      end else begin
        cnt_n = take ? cnt_q + CW'(1) : cnt_q;
        sh_n  = sh_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      bclk_q <= bclk_n;
      ws_q   <= ws_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
    end
  end

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter  int unsigned DEPTH = 32,
  parameter  int unsigned DW    = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  input  logic          flush,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] level,
  output logic          drop
);

  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic [DW-1:0] rdat_q, rdat_n;
  logic          rval_q, rval_n;
  logic          full, empty, wr_ok, rd_ok;

  always_comb begin
    full  = lvl_q == LW'(DEPTH);
    empty = lvl_q == '0;
    wr_ok = push & ~full & ~flush;
    rd_ok = pop_req & ~empty & ~flush;
    drop  = push & full & ~flush;

    wp_n   = wp_q;
    rp_n   = rp_q;
    lvl_n  = lvl_q;
    rdat_n = rdat_q;
    rval_n = rd_ok;

    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (wr_ok) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (rd_ok) begin
        rp_n   = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
        rdat_n = mem[rp_q];
      end
      lvl_n = lvl_q + LW'(wr_ok) - LW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lvl_q  <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      lvl_q  <= lvl_n;
      rdat_q <= rdat_n;
      rval_q <= rval_n;
    end
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;
  assign level    = lvl_q;

endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core
  import i2s_rx_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  parameter  int unsigned DW    = WORD_W,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          ws_i,
  input  logic          sd_i,
  input  logic          rec_en,
  input  logic          dma_en,
  input  logic [1:0]    size_sel,
  input  logic [LW-1:0] trig_lvl,
  input  logic          flush,
  input  logic          ovr_clr,
  input  logic [3:0]    irq_en,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] level,
  output logic          svc_flag,
  output logic          ovr_flag,
  output logic [3:0]    irq_flags,
  output logic          irq,
  output logic          dma_req
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [2:0] pins_s;

  i2s_rx_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({bclk_i, ws_i, sd_i}),
    .q     (pins_s)
  );

  logic          push;
  logic [DW-1:0] push_data;

  i2s_rx_deser #(.DW(DW)) u_deser (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .bclk_s      (pins_s[2]),
    .ws_s        (pins_s[1]),
    .sd_s        (pins_s[0]),
    .rec_en      (rec_en),
    .size_sel    (size_sel),
    .push_o      (push),
    .push_data_o (push_data)
  );

  logic drop;

  i2s_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (push),
    .push_data (push_data),
    .pop_req   (rd_en),
    .flush     (flush),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .level     (level),
    .drop      (drop)
  );

  logic ovr_q, ovr_n;
  logic svc;
  logic [3:0] flg;

  always_comb begin
    ovr_n = drop | (ovr_q & ~ovr_clr);
    svc   = level >= trig_lvl;
    flg   = '0;
    flg[FLG_SVC] = svc;
    flg[FLG_OVR] = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ovr_q <= 1'b0;
    else          ovr_q <= ovr_n;
  end

  assign svc_flag  = svc;
  assign ovr_flag  = ovr_q;
  assign irq_flags = flg;
  assign irq       = |(flg & irq_en);
  assign dma_req   = dma_en & svc;

endmodule

// File: rtl/i2s_rx_core_chk.sv
module i2s_rx_core_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_en,
  input logic          dma_en,
  input logic          flush,
  input logic          rd_en,
  input logic          ovr_clr,
  input logic [LW-1:0] trig_lvl,
  input logic [LW-1:0] level,
  input logic          svc_flag,
  input logic          ovr_flag,
  input logic [3:0]    irq_en,
  input logic [3:0]    irq_flags,
  input logic          irq,
  input logic          dma_req,
  input logic          rd_valid
);

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_rd_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_svc_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && trig_lvl != '0) |-> !svc_flag);

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && level < LW'(DEPTH)) |=> !ovr_flag);

  p_irq_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[3] && ovr_flag) |-> irq);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq);

  p_flag_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[0] == 1'b0) && (irq_flags[2] == 1'b0));

  p_dma_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && svc_flag) |-> dma_req);

  p_dma_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  p_no_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> (level <= $past(level)));

endmodule

bind i2s_rx_core i2s_rx_core_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rec_en    (rec_en),
  .dma_en    (dma_en),
  .flush     (flush),
  .rd_en     (rd_en),
  .ovr_clr   (ovr_clr),
  .trig_lvl  (trig_lvl),
  .level     (level),
  .svc_flag  (svc_flag),
  .ovr_flag  (ovr_flag),
  .irq_en    (irq_en),
  .irq_flags (irq_flags),
  .irq       (irq),
  .dma_req   (dma_req),
  .rd_valid  (rd_valid)
);

// File: tb/sim_i2s_rx_core.sv
`timescale 1ns/1ps
module sim_i2s_rx_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic        rec_en = 1'b0, dma_en = 1'b0;
  logic [1:0]  size_sel = 2'b01;
  logic [5:0]  trig_lvl = 6'd7;
  logic        flush = 1'b0, ovr_clr = 1'b0;
  logic [3:0]  irq_en = 4'b0000;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [5:0]  level;
  logic        svc_flag, ovr_flag, irq, dma_req;
  logic [3:0]  irq_flags;

  always #2 clk = ~clk;

  i2s_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .rec_en(rec_en), .dma_en(dma_en), .size_sel(size_sel), .trig_lvl(trig_lvl),
    .flush(flush), .ovr_clr(ovr_clr), .irq_en(irq_en), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level), .svc_flag(svc_flag),
    .ovr_flag(ovr_flag), .irq_flags(irq_flags), .irq(irq), .dma_req(dma_req)
  );

  int          checks = 0;
  int          fails  = 0;
  int          exp_lvl = 0;
  int          smp_idx = 0;
  logic [31:0] expq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every returned word with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected read data", rd_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(rd_data === e, "R1 R2 R3 R4 read data", rd_data, e);
      end
    end
  end

  task automatic send_period(input logic ws, input logic d);
    @(negedge clk);
    bclk_i = 1'b0; ws_i = ws; sd_i = d;
    repeat (4) @(negedge clk);
    bclk_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int nbits_of(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  task automatic send_burst(input int npairs, input bit rec);
    int n;
    logic carry;
    n = nbits_of(size_sel);
    rec_en = rec;
    carry = 1'b0;
    send_period(1'b1, 1'b0);
    send_period(1'b1, 1'b0);
    for (int p = 0; p < npairs; p++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [31:0] s, m;
        s = {8'hA0 + 8'(smp_idx), 8'h5B ^ 8'(smp_idx), 8'hC3 + 8'(smp_idx), 8'h1E ^ 8'(smp_idx)};
        smp_idx++;
        for (int i = 0; i < 32; i++) begin
          logic d;
          if (i == 0)       d = carry;
          else if (i <= n)  d = s[n-i];
          else              d = 1'b0;
          send_period(ch[0], d);
        end
        carry = (n == 32) ? s[0] : 1'b0;
        m = (n == 32) ? s : ((s & ((32'h1 << n) - 1)) << (32 - n));
        if (rec && exp_lvl < 32) begin
          expq.push_back(m);
          exp_lvl++;
        end
      end
    end
    send_period(1'b0, carry);
    repeat (6) @(negedge clk);
    rec_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_one();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (exp_lvl > 0) exp_lvl--;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(level == 0, "R11 level", 32'(level), 0);
    chk(!ovr_flag && !irq && !dma_req && !rd_valid, "R11 flags", {ovr_flag, irq, dma_req, rd_valid}, 0);

    // R5/R8: below trigger
    dma_en = 1'b1;
    size_sel = 2'b01;
    send_burst(3, 1'b1);
    chk(level == 6, "R2 level after 3 pairs", 32'(level), 6);
    chk(!svc_flag, "R5 svc below trigger", svc_flag, 0);
    chk(!dma_req, "R8 dma below trigger", dma_req, 0);

    send_burst(1, 1'b1);
    chk(level == 8, "R2 level after 4 pairs", 32'(level), 8);
    chk(svc_flag, "R5 svc at trigger", svc_flag, 1);
    chk(dma_req, "R8 dma with rec_en low", dma_req, 1);
    chk(irq_flags == 4'b0010, "R7 flag word", irq_flags, 4'b0010);
    irq_en = 4'b0010; @(negedge clk);
    chk(irq, "R7 svc irq enabled", irq, 1);
    irq_en = 4'b1000; @(negedge clk);
    chk(!irq, "R7 svc irq masked", irq, 0);
    dma_en = 1'b0; @(negedge clk);
    chk(!dma_req, "R8 dma disabled", dma_req, 0);
    irq_en = 4'b0000;

    for (int k = 0; k < 8; k++) rd_one();
    @(negedge clk);
    chk(level == 0, "R4 drained", 32'(level), 0);
    rd_one();
    chk(!rd_valid, "R4 empty read", rd_valid, 0);

    // R3 widths
    size_sel = 2'b00;
    send_burst(2, 1'b1);
    for (int k = 0; k < 4; k++) rd_one();
    size_sel = 2'b10;
    send_burst(2, 1'b1);
    for (int k = 0; k < 4; k++) rd_one();
    @(negedge clk);
    chk(expq.size() == 0, "R3 all width samples returned", expq.size(), 0);

    // R10 recording off
    size_sel = 2'b01;
    send_burst(2, 1'b0);
    chk(level == 0, "R10 nothing stored", 32'(level), 0);

    // R6 overrun
    send_burst(17, 1'b1);
    chk(level == 32, "R6 full level", 32'(level), 32);
    chk(ovr_flag, "R6 overrun set", ovr_flag, 1);
    irq_en = 4'b1000; @(negedge clk);
    chk(irq, "R7 overrun irq", irq, 1);
    irq_en = 4'b0000;
    rd_one();
    repeat (2) @(negedge clk);
    chk(ovr_flag, "R6 overrun sticky", ovr_flag, 1);
    for (int k = 0; k < 31; k++) rd_one();
    @(negedge clk);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    chk(!ovr_flag, "R6 overrun cleared", ovr_flag, 0);

    // R9 flush
    send_burst(2, 1'b1);
    chk(level == 4, "R9 level before flush", 32'(level), 4);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    expq.delete();
    exp_lvl = 0;
    chk(level == 0, "R9 level after flush", 32'(level), 0);
    rd_one();
    chk(!rd_valid, "R9 read after flush", rd_valid, 0);
    send_burst(1, 1'b1);
    rd_one(); rd_one();
    @(negedge clk);
    chk(expq.size() == 0 && level == 0, "R9 fresh data after flush", 32'(level), 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule